// File: doc/BRIEF.md
# Nibble-Loaded Bank Switching Controller

This block is the banking register file and address translator of a cartridge-style memory mapper. It sits on an 8-bit CPU bus and a separate video bus. CPU writes into the upper half of the address space are decoded into bank registers. Each bank number is assembled from two writes of four bits or fewer. A low-order write goes to an even register address and the upper bits go to the next odd address, so software can change one nibble without disturbing the other.

The block translates the CPU program address through three switchable 8 KiB windows and one window that is pinned to the final bank. It translates the video pattern address through eight 1 KiB windows. It also holds a write gate for the 8 KiB work RAM window and a nametable arrangement select that produces the page bit for the video memory. Memories are outside the block, which drives only their address, write-enable and write-data lines. All outputs are registered, so every translated address appears one clock after the address that produced it.

Top module: `bank_switch_ctrl`

## Requirements
- R1: After reset, every program and pattern bank register is zero, the work RAM write gate is closed, and the nametable arrangement is horizontal (mode 0).
- R2: A register write is decoded only from CPU address bits 15..12 and 1..0 (address AND 0xF003). Any address with the same value in those bits aliases the same register.
- R3: Each program bank register is 6 bits wide. A write to its even address loads bits 3..0 from data[3:0]. A write to the odd address that follows loads bits 5..4 from data[1:0]. Bits not targeted keep their value. The register pairs are 0x8000/0x8001, 0x8002/0x8003 and 0x9000/0x9001.
- R4: For CPU address bits 15..13 = 100, 101 and 110, prg_addr is {program register 0, 1 or 2, cpu_addr[12:0]}. For 111 the bank is always the last bank (PRG_BANKS-1). The bank number is cut to log2(PRG_BANKS) bits, and prg_addr follows cpu_addr one cycle later.
- R5: Each of the eight pattern bank registers is 8 bits wide. It takes bits 3..0 at its even address and bits 7..4 (from data[3:0]) at the odd address, and bits not targeted keep their value. Register k is at 0xA000 + 0x1000*(k/2) + 2*(k%2), with its high nibble at that address plus one.
- R6: chr_addr is {pattern register ppu_addr[12:10], ppu_addr[9:0]}, with the bank cut to log2(CHR_BANKS) bits, and it follows ppu_addr one cycle later.
- R7: A write to 0x9002 sets the work RAM gate from data bit 1. One cycle after a CPU write with address bits 15..13 = 011, wram_we is high only if the gate is set. When it is high, wram_addr and wram_wdata carry the written address bits 12..0 and the written data.
- R8: A write to 0xF002 selects the arrangement from data[1:0]. Mode 0 gives nt_page = ppu_addr[11], mode 1 gives ppu_addr[10], mode 2 gives 0, and mode 3 gives 1. nt_page follows ppu_addr one cycle later.
- R9: Writes to 0x4020..0x5FFF, to 0x9003 and to the decoded values 0xE000..0xF001 and 0xF003 leave all bank registers, the gate and the arrangement unchanged. A CPU address presented with cpu_wr low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Low video bus address bits |
| prg_addr | output | log2(PRG_BANKS)+13 | Program ROM address |
| chr_addr | output | log2(CHR_BANKS)+10 | Pattern ROM address |
| nt_page | output | 1 | Nametable page select |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM address |
| wram_wdata | output | 8 | Work RAM write data |

## Verification
The bench loads a low nibble and then writes the upper bits of the same register, and the reverse. A design that cleared or overwrote the other half of the register would show a wrong bank on the next address probe. It sends writes to aliased addresses with junk in bits 11..2, which catches a decoder that compares the full address. It also sends writes to the odd neighbour 0x9003, to the audio and counter slots, and to the low cartridge space, which catches decoding that spills into registers those writes must not touch. The fixed top window, the gate opening and closing around work RAM writes, and all four arrangement modes are each probed, and a long random mix of writes and probes is compared against a reference model in the bench.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;
  typedef enum logic [1:0] {
    MIR_HORZ   = 2'd0,
    MIR_VERT   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam int PRG_REG_W     = 6;
  localparam int CHR_REG_W     = 8;
  localparam int PRG_WIN_COUNT = 3;
  localparam int CHR_WIN_COUNT = 8;
  localparam int NIB_W         = 4;
endpackage

// File: rtl/bsc_regfile.sv
`timescale 1ns/1ps
module bsc_regfile
  import bsc_pkg::*;
(
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         cpu_wr,
  input  logic [15:0]                                  cpu_addr,
  input  logic [NIB_W-1:0]                             wr_nib,
  output logic [PRG_WIN_COUNT-1:0][PRG_REG_W-1:0]      prg_bank,
  output logic [CHR_WIN_COUNT-1:0][CHR_REG_W-1:0]      chr_bank,
  output logic                                         wram_en,
  output mirror_e                                      mirror
);
  localparam logic [15:0] DEC_MASK   = 16'hF003;
  localparam logic [15:0] A_WRAM_EN  = 16'h9002;
  localparam logic [15:0] A_MIRROR   = 16'hF002;

  logic [15:0] sel;
  logic        hit;

  // only the upper half of the CPU map carries registers
  assign sel = cpu_addr & DEC_MASK;
  assign hit = cpu_wr & cpu_addr[15];

  genvar g;
  generate
    for (g = 0; g < PRG_WIN_COUNT; g++) begin : g_prg
      localparam int LO_I = (g == 0) ? 'h8000 : (g == 1) ? 'h8002 : 'h9000;
      localparam logic [15:0] LO_A = LO_I[15:0];
      localparam logic [15:0] HI_A = LO_A | 16'h0001;
      always_ff @(posedge clk) begin
        if (rst) begin
          prg_bank[g] <= '0;
        end else if (hit && sel == LO_A) begin
          prg_bank[g][NIB_W-1:0] <= wr_nib;
        end else if (hit && sel == HI_A) begin
          prg_bank[g][PRG_REG_W-1:NIB_W] <= wr_nib[PRG_REG_W-NIB_W-1:0];
        end
      end
    end

    for (g = 0; g < CHR_WIN_COUNT; g++) begin : g_chr
      localparam int LO_I = 'hA000 + (g / 2) * 'h1000 + (g % 2) * 2;
      localparam logic [15:0] LO_A = LO_I[15:0];
      localparam logic [15:0] HI_A = LO_A | 16'h0001;
      always_ff @(posedge clk) begin
        if (rst) begin
          chr_bank[g] <= '0;
        end else if (hit && sel == LO_A) begin
          chr_bank[g][NIB_W-1:0] <= wr_nib;
        end else if (hit && sel == HI_A) begin
          chr_bank[g][CHR_REG_W-1:NIB_W] <= wr_nib;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wram_en <= 1'b0;
      mirror  <= MIR_HORZ;
    end else if (hit) begin
      if (sel == A_WRAM_EN) wram_en <= wr_nib[1];
      if (sel == A_MIRROR)  mirror  <= mirror_e'(wr_nib[1:0]);
    end
  end
endmodule

// File: rtl/bsc_prg_xlat.sv
`timescale 1ns/1ps
module bsc_prg_xlat
  import bsc_pkg::*;
#(
  parameter int PRG_BANKS = 64,
  localparam int BW = $clog2(PRG_BANKS),
  localparam int AW = BW + 13
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [14:0]                             cpu_addr,
  input  logic [PRG_WIN_COUNT-1:0][PRG_REG_W-1:0] prg_bank,
  output logic [AW-1:0]                           prg_addr
);
  localparam int LAST_I = PRG_BANKS - 1;
  localparam logic [PRG_REG_W-1:0] LAST_BANK = LAST_I[PRG_REG_W-1:0];

  logic [PRG_REG_W-1:0] bank;

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    bank = prg_bank[0];
      2'd1:    bank = prg_bank[1];
      2'd2:    bank = prg_bank[2];
      default: bank = LAST_BANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prg_addr <= '0;
    else     prg_addr <= {bank[BW-1:0], cpu_addr[12:0]};
  end
endmodule

// File: rtl/bsc_chr_xlat.sv
`timescale 1ns/1ps
module bsc_chr_xlat
  import bsc_pkg::*;
#(
  parameter int CHR_BANKS = 256,
  localparam int BW = $clog2(CHR_BANKS),
  localparam int AW = BW + 10
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [12:0]                             ppu_addr,
  input  logic [CHR_WIN_COUNT-1:0][CHR_REG_W-1:0] chr_bank,
  input  mirror_e                                 mirror,
  output logic [AW-1:0]                           chr_addr,
  output logic                                    nt_page
);
  logic [CHR_REG_W-1:0] bank;
  logic                 page;

  assign bank = chr_bank[ppu_addr[12:10]];

  always_comb begin
    case (mirror)
      MIR_HORZ:   page = ppu_addr[11];
      MIR_VERT:   page = ppu_addr[10];
      MIR_ONE_LO: page = 1'b0;
      default:    page = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr <= '0;
      nt_page  <= 1'b0;
    end else begin
      chr_addr <= {bank[BW-1:0], ppu_addr[9:0]};
      nt_page  <= page;
    end
  end
endmodule

// File: rtl/bank_switch_ctrl.sv
`timescale 1ns/1ps
module bank_switch_ctrl
  import bsc_pkg::*;
#(
  parameter int PRG_BANKS = 64,
  parameter int CHR_BANKS = 256,
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13,
  localparam int CHR_AW = $clog2(CHR_BANKS) + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              nt_page,
  output logic              wram_we,
  output logic [12:0]       wram_addr,
  output logic [7:0]        wram_wdata
);
  logic [PRG_WIN_COUNT-1:0][PRG_REG_W-1:0] prg_bank;
  logic [CHR_WIN_COUNT-1:0][CHR_REG_W-1:0] chr_bank;
  logic                                    wram_en;
  mirror_e                                 mirror;

  bsc_regfile u_regs (
    .clk      (clk),
    .rst      (rst),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .wr_nib   (cpu_data[NIB_W-1:0]),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .wram_en  (wram_en),
    .mirror   (mirror)
  );

  bsc_prg_xlat #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr[14:0]),
    .prg_bank (prg_bank),
    .prg_addr (prg_addr)
  );

  bsc_chr_xlat #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk      (clk),
    .rst      (rst),
    .ppu_addr (ppu_addr),
    .chr_bank (chr_bank),
    .mirror   (mirror),
    .chr_addr (chr_addr),
    .nt_page  (nt_page)
  );

  // work RAM window 0x6000-0x7FFF, passed through only while the gate is open
  always_ff @(posedge clk) begin
    if (rst) begin
      wram_we    <= 1'b0;
      wram_addr  <= '0;
      wram_wdata <= '0;
    end else begin
      wram_we    <= cpu_wr && (cpu_addr[15:13] == 3'b011) && wram_en;
      wram_addr  <= cpu_addr[12:0];
      wram_wdata <= cpu_data;
    end
  end
endmodule

// File: rtl/bsc_checker.sv
`timescale 1ns/1ps
module bsc_checker #(
  parameter int PRG_AW = 19,
  parameter int CHR_AW = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic [15:0]       cpu_addr,
  input logic [12:0]       ppu_addr,
  input logic [PRG_AW-1:0] prg_addr,
  input logic [CHR_AW-1:0] chr_addr,
  input logic              wram_we,
  input logic [12:0]       wram_addr
);
  AST_TOP_WINDOW_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!rst && cpu_addr[15:13] == 3'b111) |=> (prg_addr[PRG_AW-1:13] == '1)); // R4
  AST_PRG_OFFSET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (prg_addr[12:0] == $past(cpu_addr[12:0]))); // R4
  AST_CHR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (chr_addr[9:0] == $past(ppu_addr[9:0]))); // R6
  AST_WRAM_GATE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(cpu_wr && cpu_addr[15:13] == 3'b011)) |=> !wram_we); // R7
  AST_WRAM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!rst && cpu_wr && cpu_addr[15:13] == 3'b011) |=> (wram_addr == $past(cpu_addr[12:0]))); // R7
endmodule

bind bank_switch_ctrl bsc_checker #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .ppu_addr  (ppu_addr),
  .prg_addr  (prg_addr),
  .chr_addr  (chr_addr),
  .wram_we   (wram_we),
  .wram_addr (wram_addr)
);

// File: tb/test_bank_switch_ctrl.sv
`timescale 1ns/1ps
module test_bank_switch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [12:0] ppu_addr = '0;
  logic [18:0] prg_addr;
  logic [17:0] chr_addr;
  logic        nt_page;
  logic        wram_we;
  logic [12:0] wram_addr;
  logic [7:0]  wram_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [5:0] prg_m [3];
  logic [7:0] chr_m [8];
  logic       gate_m;
  logic [1:0] mir_m;

  always #10 clk = ~clk;

  bank_switch_ctrl i_bank_switch_ctrl (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_page(nt_page),
    .wram_we(wram_we), .wram_addr(wram_addr), .wram_wdata(wram_wdata)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    logic [15:0] s;
    int k;
    s = a & 16'hF003;
    if (a[15]) begin
      case (s)
        16'h8000: prg_m[0][3:0] = d[3:0];
        16'h8001: prg_m[0][5:4] = d[1:0];
        16'h8002: prg_m[1][3:0] = d[3:0];
        16'h8003: prg_m[1][5:4] = d[1:0];
        16'h9000: prg_m[2][3:0] = d[3:0];
        16'h9001: prg_m[2][5:4] = d[1:0];
        16'h9002: gate_m = d[1];
        16'hF002: mir_m = d[1:0];
        default: begin
          if (s[15:12] >= 4'hA && s[15:12] <= 4'hD) begin
            k = 2 * int'(s[15:12] - 4'hA) + int'(s[1]);
            if (s[0]) chr_m[k][7:4] = d[3:0];
            else      chr_m[k][3:0] = d[3:0];
          end
        end
      endcase
    end
  endtask

  function automatic logic [5:0] exp_prg(logic [15:0] a);
    if (a[14:13] == 2'd3) return 6'h3F;
    return prg_m[a[14:13]];
  endfunction

  function automatic logic exp_nt(logic [12:0] p);
    case (mir_m)
      2'd0: return p[11];
      2'd1: return p[10];
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic wram_try(string req, logic [15:0] a, logic [7:0] d);
    cpu_write(a, d);
    chk(req, {31'd0, wram_we}, {31'd0, gate_m});
    if (gate_m) begin
      chk(req, {19'd0, wram_addr}, {19'd0, a[12:0]});
      chk(req, {24'd0, wram_wdata}, {24'd0, d});
    end
  endtask

  task automatic prg_probe(string req, logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    @(negedge clk);
    chk(req, {13'd0, prg_addr}, {13'd0, exp_prg(a), a[12:0]});
  endtask

  task automatic chr_probe(string req, logic [12:0] p);
    @(negedge clk);
    ppu_addr = p;
    @(negedge clk);
    chk(req, {14'd0, chr_addr}, {14'd0, chr_m[p[12:10]], p[9:0]});
    chk(req, {31'd0, nt_page}, {31'd0, exp_nt(p)});
  endtask

  task automatic prg_all(string req);
    prg_probe(req, 16'h8123);
    prg_probe(req, 16'hA456);
    prg_probe(req, 16'hC789);
    prg_probe(req, 16'hFFFF);
  endtask

  task automatic chr_all(string req);
    for (int w = 0; w < 8; w++) chr_probe(req, 13'(w * 1024 + 37));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    logic [15:0] a;
    for (int i = 0; i < 3; i++) prg_m[i] = '0;
    for (int i = 0; i < 8; i++) chr_m[i] = '0;
    gate_m = 1'b0; mir_m = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    prg_all("R1");
    chr_all("R1");
    chr_probe("R1", 13'h0800);
    wram_try("R1", 16'h6000, 8'h55);

    // R3 nibble loading with preservation
    cpu_write(16'h8000, 8'hF5);
    cpu_write(16'h8001, 8'hFE);
    prg_probe("R3", 16'h8000);
    cpu_write(16'h8000, 8'h0A);
    prg_probe("R3", 16'h8000);
    cpu_write(16'h9001, 8'h03);
    cpu_write(16'h9000, 8'h07);
    cpu_write(16'h8003, 8'h01);
    prg_all("R3");

    // R2 aliases through the 0xF003 mask
    cpu_write(16'h8FF2, 8'h0C);
    cpu_write(16'hBAB7, 8'h09);
    prg_probe("R2", 16'hA000);
    chr_probe("R2", 13'h0C00);

    // R4 fixed top window
    prg_probe("R4", 16'hE000);
    prg_probe("R4", 16'hF3A1);

    // R5 pattern registers
    for (int k = 0; k < 8; k++) begin
      cpu_write(16'(32'hA000 + (k / 2) * 32'h1000 + (k % 2) * 2), 8'(k + 1));
      cpu_write(16'(32'hA001 + (k / 2) * 32'h1000 + (k % 2) * 2), 8'(8 + k));
    end
    chr_all("R5");
    cpu_write(16'hD003, 8'h02);
    chr_probe("R6", 13'h1FFF);

    // R7 work RAM gate
    cpu_write(16'h9002, 8'h02);
    wram_try("R7", 16'h7123, 8'hA5);
    wram_try("R7", 16'h6001, 8'h3C);
    cpu_write(16'h9002, 8'hFD);
    wram_try("R7", 16'h7FFF, 8'h11);

    // R8 arrangement modes
    for (int m = 0; m < 4; m++) begin
      cpu_write(16'hF002, 8'(m | 8'hFC));
      chr_probe("R8", 13'h0800);
      chr_probe("R8", 13'h0400);
      chr_probe("R8", 13'h0C00);
    end

    // R9 ignored writes
    cpu_write(16'h9003, 8'hFF);
    cpu_write(16'h4020, 8'hFF);
    cpu_write(16'h5FFF, 8'hFF);
    cpu_write(16'hE001, 8'hFF);
    cpu_write(16'hF000, 8'hFF);
    cpu_write(16'hF001, 8'hFF);
    cpu_write(16'hF003, 8'hFF);
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_data = 8'hFF; cpu_wr = 1'b0;
    @(negedge clk);
    prg_all("R9");
    chr_all("R9");
    wram_try("R9", 16'h6ABC, 8'h77);

    // random mix against the model
    r = $urandom(32'd1987);
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      a = 16'h8000 | 16'(r & 32'h7FFF);
      if (r[31:30] == 2'd0) a = 16'h6000 | 16'(r & 32'h1FFF);
      if (a[15:13] == 3'b011) wram_try("R7", a, 8'(r >> 16));
      else cpu_write(a, 8'(r >> 16));
      if (i % 3 == 0) begin
        r = $urandom;
        prg_probe("R4", 16'h8000 | 16'(r & 32'h7FFF));
        chr_probe("R6", 13'(r >> 16));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule